// File: doc/BRIEF.md
# Bus DMA Page-Map Address Translator

This block converts a 22-bit peripheral-bus address, as issued by a DMA master, into a main-memory physical address. The bus address is split into a page index (bits 21:9) and a byte offset within a 512-byte page (bits 8:0). The index selects one entry of a table of map registers. Each entry holds a valid flag and a 15-bit physical page frame. The physical address is the frame placed above the 9 offset bits.

Software programs the table through a register port that takes byte, word and longword writes and longword reads. Two translation ports share the table. The normal port is used by DMA traffic. When one of its lookups fails, it raises a sticky non-existent-memory error flag. The debug port gives the same answer and never touches that flag, so an observer can probe mappings without disturbing error state. The number of implemented entries and the installed memory size are parameters. An index that lies beyond the implemented entries counts as out of range.

Top module: `dma_map_xlat`

## Requirements
- R1: After reset, nxm_err is 0, both done outputs are 0, and every map entry reads back as 0, which means invalid.
- R2: An entry stores only bit 31 (valid) and bits 14:0 (page frame). Every other bit of a write is dropped, and a read returns those bits as 0.
- R3: reg_size selects the write width: 00 is byte, 01 is word, and 1x is longword. A byte or word write places wdata starting at byte lane reg_addr[1:0]. It replaces only the covered lanes and keeps the rest of the entry. A longword write replaces the whole entry.
- R4: The entry index is address bits 21:9. On success, paddr equals {frame, address bits 8:0}.
- R5: A lookup of an entry whose valid bit is 0 fails, with ok at 0. On the normal port, this failure sets nxm_err.
- R6: An index at or beyond NUM_ENTRIES fails translation. A register write to such an index is not stored and sets nxm_err. A read of such an index returns 0.
- R7: A lookup whose physical address is at or above MEM_BYTES fails. On the normal port, this failure sets nxm_err.
- R8: The debug port never changes nxm_err, whether its lookup succeeds or fails.
- R9: nxm_err stays 1 until a cycle with nxm_clr high. If a new error arrives in the same cycle as nxm_clr, the error wins and nxm_err stays 1.
- R10: done is high exactly in the cycle after a request, carrying that request's ok and paddr. It is low otherwise.
- R11: reg_rdata shows the addressed entry, as {valid, 16 zeros, frame}, in the cycle after reg_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Map register write strobe |
| reg_rd_en | input | 1 | Map register read strobe |
| reg_addr | input | 15 | Byte address into the map table (entry index times 4, plus lane) |
| reg_size | input | 2 | Write width: 00 byte, 01 word, 1x longword |
| reg_wdata | input | 32 | Write data, right-justified |
| reg_rdata | output | 32 | Registered read data |
| xl_req | input | 1 | Normal-port translation request |
| xl_addr | input | 22 | Normal-port bus address |
| xl_done | output | 1 | Normal-port result valid |
| xl_ok | output | 1 | Normal-port translation succeeded |
| xl_paddr | output | 24 | Normal-port physical address |
| dbg_req | input | 1 | Debug-port translation request |
| dbg_addr | input | 22 | Debug-port bus address |
| dbg_done | output | 1 | Debug-port result valid |
| dbg_ok | output | 1 | Debug-port translation succeeded |
| dbg_paddr | output | 24 | Debug-port physical address |
| nxm_clr | input | 1 | Write-one-to-clear strobe for nxm_err |
| nxm_err | output | 1 | Sticky non-existent-memory error |

## Verification
The hardest cases to reach are the ones where an error and a clear arrive in the same cycle, and where an index lies just past the implemented entries. Random traffic almost never reaches either. Directed sequences drive nxm_clr in the same cycle as a failing normal lookup. They also issue writes, reads and lookups at indices beyond NUM_ENTRIES. Frames are chosen on both sides of the MEM_BYTES limit. Random traffic then mixes partial writes at every lane with lookups on both ports, against a reference table kept in the bench.

// File: rtl/dma_map_pkg.sv
package dma_map_pkg;

  localparam int FRAME_W = 15;

  typedef struct packed {
    logic               valid;
    logic [FRAME_W-1:0] frame;
  } map_entry_t;

  // Register view of an entry: valid at bit 31, frame in the low bits.
  function automatic logic [31:0] entry_to_word(map_entry_t e);
    logic [31:0] w;
    w = '0;
    w[31] = e.valid;
    w[FRAME_W-1:0] = e.frame;
    return w;
  endfunction

  // Merge a partial or full write into an existing entry.
  // size: 00 byte, 01 word, 1x longword.
  function automatic map_entry_t merge_write(map_entry_t old, logic [1:0] lane,
                                             logic [1:0] size, logic [31:0] wdata);
    logic [31:0] mask, cur, nv, data;
    logic [4:0]  sh;
    map_entry_t  r;
    sh = {lane, 3'b000};
    if (size[1]) begin
      mask = 32'hFFFF_FFFF;
      data = wdata;
    end else begin
      mask = (size[0] ? 32'h0000_FFFF : 32'h0000_00FF) << sh;
      data = wdata << sh;
    end
    cur = entry_to_word(old);
    nv  = (cur & ~mask) | (data & mask);
    r.valid = nv[31];
    r.frame = nv[FRAME_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/map_store.sv
module map_store
  import dma_map_pkg::*;
#(
  parameter int NUM_ENTRIES = 1024,
  parameter int IDX_W       = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_lane,
  input  logic [1:0]       wr_size,
  input  logic [31:0]      wr_data,
  output logic             wr_oob,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  input  logic [IDX_W-1:0] lk_idx_a,
  output map_entry_t       lk_ent_a,
  input  logic [IDX_W-1:0] lk_idx_b,
  output map_entry_t       lk_ent_b
);
  localparam int ENT_AW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  map_entry_t table_q [NUM_ENTRIES];

  function automatic logic in_range(logic [IDX_W-1:0] idx);
    return (33'(idx) < 33'(NUM_ENTRIES));
  endfunction

  function automatic logic [ENT_AW-1:0] slot(logic [IDX_W-1:0] idx);
    return ENT_AW'(idx);
  endfunction

  logic wr_hit;
  assign wr_hit = wr_en && in_range(wr_idx);
  assign wr_oob = wr_en && !in_range(wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) table_q[i] <= '0;
    end else if (wr_hit) begin
      table_q[slot(wr_idx)] <= merge_write(table_q[slot(wr_idx)], wr_lane, wr_size, wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= in_range(rd_idx) ? entry_to_word(table_q[slot(rd_idx)]) : '0;
  end

  assign lk_ent_a = in_range(lk_idx_a) ? table_q[slot(lk_idx_a)] : '0;
  assign lk_ent_b = in_range(lk_idx_b) ? table_q[slot(lk_idx_b)] : '0;

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> (rd_data[30:FRAME_W] == '0)); // R2

endmodule

// File: rtl/map_lookup.sv
module map_lookup
  import dma_map_pkg::*;
#(
  parameter int          BUS_AW      = 22,
  parameter int          PAGE_BITS   = 9,
  parameter int          IDX_W       = 13,
  parameter int          PA_W        = 24,
  parameter int          NUM_ENTRIES = 1024,
  parameter int unsigned MEM_BYTES   = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [BUS_AW-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  input  map_entry_t        ent,
  output logic              fail_evt,
  output logic              done,
  output logic              ok,
  output logic [PA_W-1:0]   paddr
);
  logic [PAGE_BITS-1:0] offset;
  logic [PA_W-1:0]      pa_c;
  logic                 idx_ok, mem_ok, ok_c;

  assign idx    = addr[BUS_AW-1:PAGE_BITS];
  assign offset = addr[PAGE_BITS-1:0];
  assign pa_c   = {ent.frame, offset};
  assign idx_ok = 33'(idx) < 33'(NUM_ENTRIES);
  assign mem_ok = 33'(pa_c) < 33'(MEM_BYTES);
  assign ok_c   = idx_ok && ent.valid && mem_ok;
  assign fail_evt = req && !ok_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      ok    <= 1'b0;
      paddr <= '0;
    end else begin
      done <= req;
      if (req) begin
        ok    <= ok_c;
        paddr <= pa_c;
      end
    end
  end

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done); // R10
  AST_DONE_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done); // R10
  AST_OK_INSIDE_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (33'(paddr) < 33'(MEM_BYTES))); // R7
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (paddr[PAGE_BITS-1:0] == $past(addr[PAGE_BITS-1:0]))); // R4

endmodule

// File: rtl/nxm_status.sv
module nxm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_a,
  input  logic set_b,
  input  logic clr,
  output logic nxm
);
  logic set_any;
  assign set_any = set_a || set_b;

  always_ff @(posedge clk) begin
    if (!rst_n) nxm <= 1'b0;
    else if (set_any) nxm <= 1'b1;
    else if (clr) nxm <= 1'b0;
  end

  AST_NXM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nxm && !clr) |=> nxm); // R9
  AST_NXM_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> nxm); // R9

endmodule

// File: rtl/dma_map_xlat.sv
module dma_map_xlat
  import dma_map_pkg::*;
#(
  parameter int          BUS_AW      = 22,
  parameter int          PAGE_BITS   = 9,
  parameter int          NUM_ENTRIES = 1024,
  parameter int unsigned MEM_BYTES   = 32'h0040_0000,
  localparam int         IDX_W       = BUS_AW - PAGE_BITS,
  localparam int         RA_W        = IDX_W + 2,
  localparam int         PA_W        = FRAME_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              xl_req,
  input  logic [BUS_AW-1:0] xl_addr,
  output logic              xl_done,
  output logic              xl_ok,
  output logic [PA_W-1:0]   xl_paddr,
  input  logic              dbg_req,
  input  logic [BUS_AW-1:0] dbg_addr,
  output logic              dbg_done,
  output logic              dbg_ok,
  output logic [PA_W-1:0]   dbg_paddr,
  input  logic              nxm_clr,
  output logic              nxm_err
);
  logic [IDX_W-1:0] xl_idx, dbg_idx;
  map_entry_t       xl_ent, dbg_ent;
  logic             xl_fail, dbg_fail, wr_oob;

  map_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_idx(reg_addr[RA_W-1:2]), .wr_lane(reg_addr[1:0]),
    .wr_size(reg_size), .wr_data(reg_wdata), .wr_oob(wr_oob),
    .rd_en(reg_rd_en), .rd_idx(reg_addr[RA_W-1:2]), .rd_data(reg_rdata),
    .lk_idx_a(xl_idx), .lk_ent_a(xl_ent),
    .lk_idx_b(dbg_idx), .lk_ent_b(dbg_ent)
  );

  map_lookup #(.BUS_AW(BUS_AW), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .PA_W(PA_W),
               .NUM_ENTRIES(NUM_ENTRIES), .MEM_BYTES(MEM_BYTES)) u_xl (
    .clk(clk), .rst_n(rst_n), .req(xl_req), .addr(xl_addr), .idx(xl_idx),
    .ent(xl_ent), .fail_evt(xl_fail), .done(xl_done), .ok(xl_ok), .paddr(xl_paddr)
  );

  map_lookup #(.BUS_AW(BUS_AW), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .PA_W(PA_W),
               .NUM_ENTRIES(NUM_ENTRIES), .MEM_BYTES(MEM_BYTES)) u_dbg (
    .clk(clk), .rst_n(rst_n), .req(dbg_req), .addr(dbg_addr), .idx(dbg_idx),
    .ent(dbg_ent), .fail_evt(dbg_fail), .done(dbg_done), .ok(dbg_ok), .paddr(dbg_paddr)
  );

  // Only the normal port and out-of-range writes feed the status flag.
  nxm_status u_nxm (
    .clk(clk), .rst_n(rst_n), .set_a(xl_fail), .set_b(wr_oob),
    .clr(nxm_clr), .nxm(nxm_err)
  );

  AST_DBG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!nxm_err && !xl_fail && !wr_oob) |=> !nxm_err); // R8
  AST_XL_FAIL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fail |=> (nxm_err && xl_done && !xl_ok)); // R5
  AST_OOB_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oob |=> nxm_err); // R6
  AST_DBG_FAIL_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_fail |=> (dbg_done && !dbg_ok)); // R8

endmodule

// File: tb/dma_map_xlat_test.sv
module dma_map_xlat_test;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 1024;
  localparam int unsigned MEMB = 32'h0040_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [14:0] reg_addr = '0;
  logic [1:0]  reg_size = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic xl_req = 0, dbg_req = 0, nxm_clr = 0;
  logic [21:0] xl_addr = '0, dbg_addr = '0;
  logic xl_done, xl_ok, dbg_done, dbg_ok, nxm_err;
  logic [23:0] xl_paddr, dbg_paddr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] model [NENT];
  bit exp_nxm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_map_xlat uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xl_req(xl_req), .xl_addr(xl_addr), .xl_done(xl_done), .xl_ok(xl_ok), .xl_paddr(xl_paddr),
    .dbg_req(dbg_req), .dbg_addr(dbg_addr), .dbg_done(dbg_done), .dbg_ok(dbg_ok),
    .dbg_paddr(dbg_paddr), .nxm_clr(nxm_clr), .nxm_err(nxm_err)
  );

  task automatic chk(bit cond, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Bench restatement of the write merge: byte by byte.
  function automatic logic [31:0] bench_merge(logic [31:0] old, logic [1:0] lane,
                                              logic [1:0] sz, logic [31:0] d);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) begin
      int src;
      bit en;
      src = b - int'(lane);
      if (sz[1]) begin en = 1; src = b; end
      else if (sz == 2'b01) en = (src == 0 || src == 1);
      else en = (src == 0);
      if (en) r[8*b +: 8] = d[8*src +: 8];
    end
    return r & 32'h8000_7FFF;
  endfunction

  function automatic bit bench_ok(logic [21:0] a, output logic [23:0] pa);
    int idx;
    logic [31:0] e;
    idx = int'(a >> 9);
    e = (idx < NENT) ? model[idx] : 32'h0;
    pa = {e[14:0], a[8:0]};
    return (idx < NENT) && e[31] && (32'(pa) < MEMB);
  endfunction

  task automatic do_write(int idx, logic [1:0] lane, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 15'(idx * 4) | 15'(lane); reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
    if (idx < NENT) model[idx] = bench_merge(model[idx], lane, sz, d);
    else exp_nxm = 1;
  endtask

  task automatic do_read(int idx, string rq);
    logic [31:0] e;
    e = (idx < NENT) ? model[idx] : 32'h0;
    @(negedge clk);
    reg_rd_en = 1; reg_addr = 15'(idx * 4);
    @(negedge clk);
    reg_rd_en = 0;
    chk(reg_rdata == e, rq, reg_rdata, e);
  endtask

  task automatic do_xl(logic [21:0] a, bit dbg, string rq);
    logic [23:0] pa;
    bit ok;
    ok = bench_ok(a, pa);
    @(negedge clk);
    if (dbg) begin dbg_req = 1; dbg_addr = a; end
    else begin xl_req = 1; xl_addr = a; end
    @(negedge clk);
    dbg_req = 0; xl_req = 0;
    if (!dbg && !ok) exp_nxm = 1;
    if (dbg) begin
      chk(dbg_done && dbg_ok == ok, rq, {30'b0, dbg_done, dbg_ok}, {30'b0, 1'b1, ok});
      if (ok) chk(dbg_paddr == pa, rq, 32'(dbg_paddr), 32'(pa));
    end else begin
      chk(xl_done && xl_ok == ok, rq, {30'b0, xl_done, xl_ok}, {30'b0, 1'b1, ok});
      if (ok) chk(xl_paddr == pa, rq, 32'(xl_paddr), 32'(pa));
    end
    chk(nxm_err == exp_nxm, dbg ? "R8 nxm" : "R5/R7 nxm", 32'(nxm_err), 32'(exp_nxm));
  endtask

  task automatic do_clr();
    @(negedge clk); nxm_clr = 1;
    @(negedge clk); nxm_clr = 0;
    exp_nxm = 0;
    chk(nxm_err == 0, "R9 clear", 32'(nxm_err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NENT; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(nxm_err == 0 && xl_done == 0 && dbg_done == 0, "R1 reset flags",
        {29'b0, nxm_err, xl_done, dbg_done}, 0);
    do_read(5, "R1 entry after reset");
    // R2 dropped bits
    do_write(3, 2'd0, 2'b10, 32'hFFFF_FFFF);
    do_read(3, "R2 masked longword");
    // R3 lane merges (R11 read-back)
    do_write(4, 2'd0, 2'b10, 32'h0);
    do_write(4, 2'd1, 2'b00, 32'h0000_00AB);
    do_write(4, 2'd3, 2'b00, 32'h0000_0080);
    do_read(4, "R3 byte lanes");
    chk(model[4] == 32'h8000_2B00, "R3 model", model[4], 32'h8000_2B00);
    do_write(4, 2'd2, 2'b01, 32'h0000_1234);
    do_read(4, "R3 word lane 2");
    do_write(4, 2'd3, 2'b01, 32'h0000_00FF);
    do_read(4, "R11 word at lane 3");
    // R7 beyond memory
    do_xl({13'd3, 9'h010}, 0, "R7 frame above limit");
    do_clr();
    // R4 translation
    do_write(6, 2'd0, 2'b11, 32'h8000_0010);
    do_xl({13'd6, 9'h1FF}, 0, "R4 basic");
    // R10 done drops the cycle after
    @(negedge clk);
    chk(xl_done == 0, "R10 done low", 32'(xl_done), 0);
    // R7 boundary
    do_write(8, 2'd0, 2'b10, 32'h8000_1FFF);
    do_xl({13'd8, 9'h1FF}, 0, "R7 last byte fits");
    do_write(9, 2'd0, 2'b10, 32'h8000_2000);
    do_xl({13'd9, 9'h000}, 1, "R8 debug above limit");
    do_xl({13'd9, 9'h000}, 0, "R7 first byte out");
    do_clr();
    // R5 invalid entry, R8 debug failure quiet
    do_xl({13'd7, 9'h0}, 1, "R8 debug invalid");
    do_xl({13'd7, 9'h0}, 0, "R5 invalid entry");
    do_clr();
    // R6 out-of-range index
    do_write(2000, 2'd0, 2'b10, 32'h8000_0001);
    chk(nxm_err == 1, "R6 oob write sets nxm", 32'(nxm_err), 1);
    do_read(2000, "R6 oob read zero");
    do_clr();
    do_xl({13'd2000, 9'h0}, 0, "R6 oob translate");
    do_clr();
    // R9 set wins over clear
    @(negedge clk);
    xl_req = 1; xl_addr = {13'd7, 9'h0}; nxm_clr = 1;
    @(negedge clk);
    xl_req = 0; nxm_clr = 0; exp_nxm = 1;
    chk(nxm_err == 1, "R9 set beats clear", 32'(nxm_err), 1);
    @(negedge clk);
    chk(nxm_err == 1, "R9 sticky", 32'(nxm_err), 1);
    do_clr();
    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, idx;
      logic [31:0] d;
      op = int'($urandom_range(0, 9));
      idx = int'($urandom_range(0, 15));
      if (($urandom_range(0, 15)) == 0) idx = NENT + int'($urandom_range(0, 3));
      d = $urandom;
      if (d[29]) d[14:13] = 2'b00;
      case (op)
        0, 1, 2: do_write(idx, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), d);
        3:       do_read(idx, "R11 random read");
        4, 5, 6: do_xl({13'(idx), 9'($urandom)}, 0, "R4 random normal");
        7, 8:    do_xl({13'(idx), 9'($urandom)}, 1, "R8 random debug");
        default: do_clr();
      endcase
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule